// File: doc/BRIEF.md
# Gated Time Stamp Tick Generator

This block produces the time stamp tick that several independent readout controllers share, and it keeps its own local time stamp counter. By default the tick comes from a divider that yields one tick every `DIV` system clock cycles. With `DIV` set to 4, a 40 MHz system clock gives a 10 MHz tick. A configuration input can select an external clock instead. That clock passes through a synchronizer, and each of its rising edges becomes a tick that lasts one system clock cycle.

A run-enable input (`go`) gates the tick. While `go` is low, no tick leaves the block and no counter advances. This is the time to clear every counter that listens to the tick. When `go` rises at the end of the start-up sequence, the first tick comes after a fixed number of cycles, so all downstream counters start together. A clear request that arrives while `go` is high is refused, and it sets a sticky error flag.

A latch strobe, for example the accepted-trigger pulse, copies the counter into a one-entry holding slot. The slot is offered on a valid/ready output stream, and counting continues meanwhile. Back-pressure rules for that stream:
- While `snap_valid` is high and `snap_ready` is low, `snap_data` holds its value and further strobes are dropped.
- A strobe in the same cycle as a completed handshake loads the slot again.

Top module: `tstamp_gate`

## Requirements
- R1: With `go` high and `ext_sel` low, `tick` is high for exactly one cycle in every `DIV` (default 4) cycles.
- R2: The divider phase is held at zero while `go` is low. After the first clock edge that samples `go` high, `tick` first goes high just after the `DIV`-th edge.
- R3: While `go` is low, `tick` is low and `ts_count` does not change, except through a clear.
- R4: `clr_cmd` sampled high with `go` low sets `ts_count` to zero at that clock edge.
- R5: `clr_cmd` sampled high with `go` high leaves `ts_count` untouched and sets `clr_err`. `clr_err` stays high until `rst_n` is asserted.
- R6: Each clock edge that samples `tick` high adds one to `ts_count`. The counter is `TS_W` bits wide (default 48) and wraps from all ones to zero.
- R7: With `ext_sel` high, each rising edge of `ext_clk` gives exactly one single-cycle `tick`, three edges later through a two-stage synchronizer. The internal divider then has no effect on `tick`.
- R8: A clock edge that samples `latch_stb` high while the slot is free or being drained loads `snap_data` with the `ts_count` value present before that edge, and sets `snap_valid`.
- R9: While `snap_valid` is high and `snap_ready` is low, `snap_data` is stable and strobes are dropped. An edge that samples `snap_valid` and `snap_ready` high with no strobe clears `snap_valid`.
- R10: After reset, `tick`, `ts_count`, `snap_valid` and `clr_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Run enable; vetoes the tick while low |
| ext_sel | input | 1 | 1 selects the external clock as tick source |
| ext_clk | input | 1 | External clock, asynchronous |
| clr_cmd | input | 1 | Counter clear request |
| latch_stb | input | 1 | Copy counter into the holding slot |
| snap_ready | input | 1 | Consumer accepts the held value |
| tick | output | 1 | Gated time stamp tick |
| ts_count | output | TS_W | Local time stamp counter |
| snap_valid | output | 1 | Holding slot contains a value |
| snap_data | output | TS_W | Held counter value |
| clr_err | output | 1 | Sticky flag: clear refused while running |

## Verification
The assertions check on every cycle the relations that hold from one edge to the next: no tick while `go` is low, the counter stepping by one per tick (including the wrap) and staying still otherwise, clears being honored or refused according to `go`, the error flag staying sticky, and held data staying stable under back-pressure. Only the bench scenarios can show behaviour spread over many cycles. These are the exact spacing of internal ticks, the fixed delay from the rise of `go` to the first tick, the one-tick-per-edge count from the external clock, and a narrow counter instance wrapping to zero after a whole period of ticks.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  localparam int unsigned TS_W_DEF = 48;
  localparam int unsigned DIV_DEF  = 4;
  localparam int unsigned SYNC_DEF = 2;

  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } tick_src_e;
endpackage

// File: rtl/tsg_divider.sv
module tsg_divider #(
  parameter int unsigned DIV = tsg_pkg::DIV_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pulse
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  // phase parks at zero while stopped, so restart latency is fixed
  always_ff @(posedge clk) begin
    if (!rst_n)             phase <= '0;
    else if (!run)          phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign pulse = run && (phase == LAST);
endmodule

// File: rtl/tsg_ext_edge.sv
module tsg_ext_edge #(
  parameter int unsigned SYNC = tsg_pkg::SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [SYNC:0] stage;

  generate
    for (genvar g = 0; g <= SYNC; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage[g] <= 1'b0;
          else        stage[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage[g] <= 1'b0;
          else        stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  // last synchronizer flop against one extra history flop
  assign rise = stage[SYNC-1] & ~stage[SYNC];
endmodule

// File: rtl/tsg_counter.sv
module tsg_counter #(
  parameter int unsigned W = tsg_pkg::TS_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         clr,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)   value <= '0;
    else if (clr) value <= '0;
    else if (adv) value <= value + 1'b1;
  end
endmodule

// File: rtl/tsg_snapshot.sv
module tsg_snapshot #(
  parameter int unsigned W = tsg_pkg::TS_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] src,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);
  logic take;
  assign take = stb && (!valid || ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (take) begin
      valid <= 1'b1;
      data  <= src;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tstamp_gate.sv
module tstamp_gate #(
  parameter int unsigned TS_W = tsg_pkg::TS_W_DEF,
  parameter int unsigned DIV  = tsg_pkg::DIV_DEF,
  parameter int unsigned SYNC = tsg_pkg::SYNC_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            ext_sel,
  input  logic            ext_clk,
  input  logic            clr_cmd,
  input  logic            latch_stb,
  input  logic            snap_ready,
  output logic            tick,
  output logic [TS_W-1:0] ts_count,
  output logic            snap_valid,
  output logic [TS_W-1:0] snap_data,
  output logic            clr_err
);
  import tsg_pkg::*;

  tick_src_e src_sel;
  logic      int_pulse, ext_rise, src_pulse, tick_q, clr_ok;

  assign src_sel = tick_src_e'(ext_sel);

  tsg_divider #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(go), .pulse(int_pulse)
  );

  tsg_ext_edge #(.SYNC(SYNC)) u_ext (
    .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .rise(ext_rise)
  );

  assign src_pulse = (src_sel == SRC_EXTERNAL) ? ext_rise : int_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= go & src_pulse;
  end

  // registered tick, vetoed at once when go falls
  assign tick   = tick_q & go;
  assign clr_ok = clr_cmd & ~go;

  tsg_counter #(.W(TS_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(tick), .clr(clr_ok), .value(ts_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)             clr_err <= 1'b0;
    else if (clr_cmd && go) clr_err <= 1'b1;
  end

  tsg_snapshot #(.W(TS_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .stb(latch_stb), .src(ts_count),
    .ready(snap_ready), .valid(snap_valid), .data(snap_data)
  );
endmodule

// File: rtl/tstamp_gate_chk.sv
module tstamp_gate_chk #(
  parameter int unsigned TS_W = 48
) (
  input logic            clk,
  input logic            rst_n,
  input logic            go,
  input logic            clr_cmd,
  input logic            snap_ready,
  input logic            tick,
  input logic [TS_W-1:0] ts_count,
  input logic            snap_valid,
  input logic [TS_W-1:0] snap_data,
  input logic            clr_err
);
  // R3
  no_tick_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> !tick);

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(clr_cmd && !go)) |=> $stable(ts_count));

  // R6
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ts_count == TS_W'($past(ts_count) + 1'b1));

  // R4
  clear_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd && !go) |=> ts_count == '0);

  // R5
  clear_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cmd && go) |=> clr_err);

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> clr_err);

  // R9
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_valid && !snap_ready) |=> (snap_valid && $stable(snap_data)));
endmodule

bind tstamp_gate tstamp_gate_chk #(.TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .clr_cmd(clr_cmd),
  .snap_ready(snap_ready), .tick(tick), .ts_count(ts_count),
  .snap_valid(snap_valid), .snap_data(snap_data), .clr_err(clr_err)
);

// File: tb/tstamp_gate_bench.sv
module tstamp_gate_bench;
  localparam int unsigned TS_W = 48;
  localparam int unsigned NW   = 4;

  logic clk = 1'b0;
  logic rst_n, go, ext_sel, ext_clk, clr_cmd, latch_stb, snap_ready;
  logic tick, snap_valid, clr_err;
  logic [TS_W-1:0] ts_count, snap_data;
  logic n_tick, n_valid, n_err;
  logic [NW-1:0] n_count, n_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  tstamp_gate u_tstamp_gate (
    .clk(clk), .rst_n(rst_n), .go(go), .ext_sel(ext_sel), .ext_clk(ext_clk),
    .clr_cmd(clr_cmd), .latch_stb(latch_stb), .snap_ready(snap_ready),
    .tick(tick), .ts_count(ts_count), .snap_valid(snap_valid),
    .snap_data(snap_data), .clr_err(clr_err)
  );

  tstamp_gate #(.TS_W(NW)) u_tstamp_gate_narrow (
    .clk(clk), .rst_n(rst_n), .go(go), .ext_sel(ext_sel), .ext_clk(ext_clk),
    .clr_cmd(clr_cmd), .latch_stb(latch_stb), .snap_ready(snap_ready),
    .tick(n_tick), .ts_count(n_count), .snap_valid(n_valid),
    .snap_data(n_data), .clr_err(n_err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic stop_and_clear();
    go = 1'b0; step(1);
    clr_cmd = 1'b1; step(1);
    clr_cmd = 1'b0;
  endtask

  task automatic t_reset();
    check(tick == 1'b0, "R10 tick", 64'(tick), 0);
    check(ts_count == '0, "R10 count", 64'(ts_count), 0);
    check(snap_valid == 1'b0, "R10 valid", 64'(snap_valid), 0);
    check(clr_err == 1'b0, "R10 err", 64'(clr_err), 0);
  endtask

  task automatic t_stopped();
    int seen = 0;
    go = 1'b0; ext_sel = 1'b0;
    for (int i = 0; i < 20; i++) begin step(1); if (tick) seen++; end
    check(seen == 0, "R3 ticks while stopped", 64'(seen), 0);
    check(ts_count == '0, "R3 count while stopped", ts_count, 0);
  endtask

  task automatic t_internal();
    logic [TS_W-1:0] c0 = ts_count;
    int bad = 0;
    go = 1'b1;
    for (int i = 1; i <= 42; i++) begin
      step(1);
      if (tick !== ((i % 4) == 0)) bad++;
      if (i == 4) check(tick == 1'b1, "R2 first tick after go", 64'(tick), 1);
      if (i == 3) check(tick == 1'b0, "R2 no early tick", 64'(tick), 0);
    end
    check(bad == 0, "R1 tick spacing", 64'(bad), 0);
    go = 1'b0; #1;
    check(tick == 1'b0, "R3 veto on go low", 64'(tick), 0);
    step(2);
    check(ts_count - c0 == 10, "R6 count per window", ts_count - c0, 10);
  endtask

  task automatic t_clear_refused();
    logic [TS_W-1:0] c0;
    go = 1'b1; step(6);
    c0 = ts_count;
    clr_cmd = 1'b1; step(1); clr_cmd = 1'b0;
    check(ts_count >= c0 && ts_count != '0, "R5 clear ignored", ts_count, c0);
    check(clr_err == 1'b1, "R5 error set", 64'(clr_err), 1);
    go = 1'b0; step(2);
  endtask

  task automatic t_clear_ok();
    go = 1'b0;
    clr_cmd = 1'b1; step(1); clr_cmd = 1'b0;
    check(ts_count == '0, "R4 clear while stopped", ts_count, 0);
    check(clr_err == 1'b1, "R5 error sticky", 64'(clr_err), 1);
  endtask

  task automatic t_external();
    int seen = 0;
    int dbl = 0;
    logic prev = 1'b0;
    ext_sel = 1'b1; ext_clk = 1'b0; go = 1'b1;
    for (int k = 0; k < 5; k++) begin
      for (int j = 0; j < 6; j++) begin
        ext_clk = (j < 3);
        step(1);
        if (tick) seen++;
        if (tick && prev) dbl++;
        prev = tick;
      end
    end
    check(seen == 5, "R7 one tick per edge", 64'(seen), 5);
    check(dbl == 0, "R7 single-cycle tick", 64'(dbl), 0);
    step(4);
    go = 1'b0; step(2);
    check(ts_count == 5, "R7 external count", ts_count, 5);
    for (int k = 0; k < 3; k++) begin
      ext_clk = 1'b1; step(3); ext_clk = 1'b0; step(3);
    end
    check(ts_count == 5, "R3 external vetoed", ts_count, 5);
    ext_sel = 1'b0;
  endtask

  task automatic t_snapshot();
    logic [TS_W-1:0] c;
    int moved = 0;
    stop_and_clear();
    go = 1'b1; snap_ready = 1'b0; step(9);
    c = ts_count;
    latch_stb = 1'b1; step(1);
    check(snap_valid == 1'b1, "R8 valid after strobe", 64'(snap_valid), 1);
    check(snap_data == c, "R8 captured value", snap_data, c);
    for (int i = 0; i < 8; i++) begin
      step(1);
      if (snap_data != c || !snap_valid) moved++;
    end
    check(moved == 0, "R9 held under back-pressure", 64'(moved), 0);
    check(ts_count != c, "R9 counting continues", ts_count, c);
    latch_stb = 1'b0; snap_ready = 1'b1; step(1);
    check(snap_valid == 1'b0, "R9 drained", 64'(snap_valid), 0);
    latch_stb = 1'b1; step(1);
    c = ts_count; step(1);
    check(snap_valid == 1'b1 && snap_data == c, "R9 reload on handshake",
          snap_data, c);
    latch_stb = 1'b0; step(1);
    check(snap_valid == 1'b0, "R9 drained again", 64'(snap_valid), 0);
    snap_ready = 1'b0;
    go = 1'b0; step(2);
  endtask

  task automatic t_wrap();
    stop_and_clear();
    go = 1'b1; step(66);
    go = 1'b0; step(2);
    check(ts_count == 16, "R6 wide count", ts_count, 16);
    check(n_count == '0, "R6 narrow wrap", 64'(n_count), 0);
  endtask

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; go = 1'b0; ext_sel = 1'b0; ext_clk = 1'b0;
    clr_cmd = 1'b0; latch_stb = 1'b0; snap_ready = 1'b0;
    step(3);
    rst_n = 1'b1; step(1);
    t_reset();
    t_stopped();
    t_internal();
    t_internal();
    t_clear_refused();
    t_clear_ok();
    t_external();
    t_snapshot();
    t_wrap();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule